// File: doc/BRIEF.md
# Key-Guarded Oscillator Configuration Register

This block keeps the configuration word for an external programmable clock synthesizer behind a software key. It has two registers on a small word-addressed register bus: a key register and the oscillator word. The oscillator word cannot be changed until the key register has been loaded with the unlock value. It is changed again only after that, and any other value written to the key register closes the guard again. The three divider fields of the oscillator word drive the synthesizer directly. A one-cycle strobe marks each accepted change so that the synthesizer can reload.

The oscillator word is 32 bits wide. The low 19 bits hold the feedback (VCO) divider, the reference divider and the output select. The 13 bits above them are plain storage: they are kept and read back so that software can do a read-modify-write, and they do not drive the synthesizer. Stored divider fields never fall below their legal floors. The synthesizer applies its own fixed offsets.

Reads are combinational from the bus address. A write takes effect at the clock edge where the write strobe is high. The asynchronous active-low reset is synchronised inside the block before it reaches the register state.

Top module: `osccfg_ctrl`

## Requirements
- R1: After reset the guard is closed, the key register reads 0x0001_0000 and the oscillator word reads the parameter default (0x0002_1430: VCO divider 48, reference divider 10, select 2).
- R2: Writing exactly 0x0000_A05F to the key register (word address 2) opens the guard. From the next cycle `locked` is 0 and the key register reads 0x0000_A05F.
- R3: Writing any other 32-bit value to the key register, including 0 and 0x0001_A05F, closes the guard. A read then returns bit 16 = 1, and bits 15:0 hold the low 16 bits of the value written.
- R4: While the guard is closed, a write to the oscillator word (word address 5) changes neither its readback nor the divider outputs.
- R5: While the guard is open, an oscillator write sets the outputs in the next cycle: `vco_div` takes bits 8:0, `ref_div` takes bits 15:9 and `out_sel` takes bits 18:16.
- R6: Bits 31:19 of an accepted oscillator write are stored and read back unchanged at the same positions.
- R7: A VCO divider below 4 is stored as 4, and a reference divider of 0 is stored as 1. All other values are stored as written.
- R8: `cfg_update` is high for exactly the one cycle after each accepted oscillator write, and is low at all other times.
- R9: Other word addresses read as 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| vco_div | output | 9 | Stored feedback divider field |
| ref_div | output | 7 | Stored reference divider field |
| out_sel | output | 3 | Stored output select field |
| locked | output | 1 | High while oscillator writes are refused |
| cfg_update | output | 1 | One-cycle strobe after an accepted oscillator write |

## Verification
A guard stuck open or closed shows up on `locked` and bit 16 of the key readback in the first cycle after the key write. Field misplacement or a missing floor shows up on the divider outputs and the oscillator readback in the cycle right after the write. The bench sweeps every VCO divider value, and every reference divider value along the way, so a broken bit or a wrong clamp boundary cannot hide. A strobe that is missed, repeated or spurious is seen at the sample point directly after each write.

// File: rtl/osccfg_pkg.sv
package osccfg_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  // Register selection decoded from the word address
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_KEY  = 2'd1,
    SEL_OSC  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/osccfg_rst_sync.sv
module osccfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_n;

  always_comb begin
    stage_n = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_n;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/osccfg_key.sv
module osccfg_key #(
  parameter int unsigned          DATA_W = 32,
  parameter int unsigned          KEY_W  = 16,
  parameter logic [DATA_W-1:0]    UNLOCK = 32'h0000_A05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic [KEY_W-1:0]  key_lo
);

  logic             locked_q, locked_n;
  logic [KEY_W-1:0] key_q, key_n;
  logic             match;

  assign match = (wdata == UNLOCK);

  always_comb begin
    locked_n = locked_q;
    key_n    = key_q;
    if (we) begin
      locked_n = !match;
      key_n    = wdata[KEY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      key_q    <= '0;
    end else begin
      locked_q <= locked_n;
      key_q    <= key_n;
    end
  end

  assign locked = locked_q;
  assign key_lo = key_q;

  // R2: the exact unlock value opens the guard
  a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == UNLOCK) |=> !locked);

  // R3: every other value closes it and records its low half
  a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata != UNLOCK) |=> (locked && key_lo == $past(wdata[KEY_W-1:0])));

  // R9: the guard state moves only on a key write
  a_r9_key_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(locked) && $stable(key_lo)));

endmodule

// File: rtl/osccfg_field.sv
module osccfg_field #(
  parameter int unsigned   W   = 9,
  parameter int unsigned   MIN = 0,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] fix_val;
  logic [W-1:0] q_reg, q_nxt;

  generate
    if (MIN > 0) begin : g_floor
      assign fix_val = (d < W'(MIN)) ? W'(MIN) : d;
    end else begin : g_pass
      assign fix_val = d;
    end
  endgenerate

  always_comb begin
    q_nxt = q_reg;
    if (we) begin
      q_nxt = fix_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= RST;
    end else begin
      q_reg <= q_nxt;
    end
  end

  assign q = q_reg;

  generate
    if (MIN > 0) begin : g_floor_chk
      // R7: a stored divider never falls below its floor
      a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q >= W'(MIN)));
    end
  endgenerate

  // R4: without an enable the field holds
  a_r4_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/osccfg_rdmux.sv
module osccfg_rdmux
  import osccfg_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  reg_sel_e       sel,
  input  logic [DW-1:0]  key_word,
  input  logic [DW-1:0]  osc_word,
  output logic [DW-1:0]  rdata
);

  always_comb begin
    unique case (sel)
      SEL_KEY: rdata = key_word;
      SEL_OSC: rdata = osc_word;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/osccfg_ctrl.sv
module osccfg_ctrl
  import osccfg_pkg::*;
#(
  parameter int unsigned        VCO_W    = 9,
  parameter int unsigned        REF_W    = 7,
  parameter int unsigned        SEL_W    = 3,
  parameter int unsigned        VCO_MIN  = 4,
  parameter int unsigned        REF_MIN  = 1,
  parameter int unsigned        KEY_W    = 16,
  parameter logic [ADDR_W-1:0]  KEY_IDX  = 4'd2,
  parameter logic [ADDR_W-1:0]  OSC_IDX  = 4'd5,
  parameter logic [DATA_W-1:0]  UNLOCK   = 32'h0000_A05F,
  parameter logic [DATA_W-1:0]  OSC_DEF  = 32'h0002_1430
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [VCO_W-1:0]  vco_div,
  output logic [REF_W-1:0]  ref_div,
  output logic [SEL_W-1:0]  out_sel,
  output logic              locked,
  output logic              cfg_update
);

  localparam int unsigned REF_LO  = VCO_W;
  localparam int unsigned SEL_LO  = VCO_W + REF_W;
  localparam int unsigned FIELD_W = SEL_LO + SEL_W;
  localparam int unsigned UP_W    = DATA_W - FIELD_W;
  localparam int unsigned PAD_W   = DATA_W - KEY_W - 1;

  logic             rst_sync_n;
  reg_sel_e         sel;
  logic             key_we;
  logic             osc_we;
  logic             guard_closed;
  logic [KEY_W-1:0] key_lo;
  logic [UP_W-1:0]  upper_q;
  logic             upd_q, upd_n;
  logic [DATA_W-1:0] key_word;
  logic [DATA_W-1:0] osc_word;

  osccfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    if (bus_addr == KEY_IDX) begin
      sel = SEL_KEY;
    end else if (bus_addr == OSC_IDX) begin
      sel = SEL_OSC;
    end else begin
      sel = SEL_NONE;
    end
  end

  assign key_we = bus_wr && (sel == SEL_KEY);
  assign osc_we = bus_wr && (sel == SEL_OSC) && !guard_closed;

  osccfg_key #(
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .UNLOCK (UNLOCK)
  ) u_key (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (key_we),
    .wdata  (bus_wdata),
    .locked (guard_closed),
    .key_lo (key_lo)
  );

  osccfg_field #(
    .W   (VCO_W),
    .MIN (VCO_MIN),
    .RST (OSC_DEF[VCO_W-1:0])
  ) u_vco (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (osc_we),
    .d     (bus_wdata[VCO_W-1:0]),
    .q     (vco_div)
  );

  osccfg_field #(
    .W   (REF_W),
    .MIN (REF_MIN),
    .RST (OSC_DEF[SEL_LO-1:REF_LO])
  ) u_ref (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (osc_we),
    .d     (bus_wdata[SEL_LO-1:REF_LO]),
    .q     (ref_div)
  );

  osccfg_field #(
    .W   (SEL_W),
    .MIN (0),
    .RST (OSC_DEF[FIELD_W-1:SEL_LO])
  ) u_sel (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (osc_we),
    .d     (bus_wdata[FIELD_W-1:SEL_LO]),
    .q     (out_sel)
  );

  osccfg_field #(
    .W   (UP_W),
    .MIN (0),
    .RST (OSC_DEF[DATA_W-1:FIELD_W])
  ) u_upper (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (osc_we),
    .d     (bus_wdata[DATA_W-1:FIELD_W]),
    .q     (upper_q)
  );

  always_comb begin
    upd_n = osc_we;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_n;
    end
  end

  assign key_word = {{PAD_W{1'b0}}, guard_closed, key_lo};
  assign osc_word = {upper_q, out_sel, ref_div, vco_div};

  osccfg_rdmux #(
    .DW (DATA_W)
  ) u_rd (
    .sel      (sel),
    .key_word (key_word),
    .osc_word (osc_word),
    .rdata    (bus_rdata)
  );

  assign locked     = guard_closed;
  assign cfg_update = upd_q;

  // R4: a refused oscillator write leaves the whole word untouched
  a_r4_locked_ignore: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OSC_IDX && locked) |=> $stable(osc_word));

  // R6: the upper bits follow an accepted write
  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OSC_IDX && !locked) |=> (upper_q == $past(bus_wdata[DATA_W-1:FIELD_W])));

  // R8: the strobe follows an accepted write and nothing else
  a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_update |-> $past(bus_wr && bus_addr == OSC_IDX && !locked));

  // R8: an accepted write always raises the strobe
  a_r8_strobe_seen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OSC_IDX && !locked) |=> cfg_update);

endmodule

// File: tb/osccfg_ctrl_tb.sv
module osccfg_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] KEY_A = 4'd2;
  localparam logic [3:0] OSC_A = 4'd5;
  localparam logic [31:0] DEF_WORD = 32'h0002_1430;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [8:0]  vco_div;
  logic [6:0]  ref_div;
  logic [2:0]  out_sel;
  logic        locked;
  logic        cfg_update;

  int total;
  int bad;

  osccfg_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .vco_div    (vco_div),
    .ref_div    (ref_div),
    .out_sel    (out_sel),
    .locked     (locked),
    .cfg_update (cfg_update)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  // Drive a write at a falling edge; returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w);
    logic [8:0] v;
    logic [6:0] r;
    v = w[8:0];
    r = w[15:9];
    if (v < 9'd4) v = 9'd4;
    if (r == 7'd0) r = 7'd1;
    return {w[31:16], r, v};
  endfunction

  initial begin
    #(CLK_PERIOD*150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] cur;
    total = 0; bad = 0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(KEY_A, rv); check("R1 key", rv, 32'h0001_0000);
    rd(OSC_A, rv); check("R1 osc", rv, DEF_WORD);
    check("R1 locked", {31'd0, locked}, 32'd1);
    check("R1 fields", {13'd0, out_sel, ref_div, vco_div}, DEF_WORD);
    check("R8 idle", {31'd0, cfg_update}, 32'd0);

    // R4 write while closed
    wr(OSC_A, 32'hFFFF_FFFF);
    rd(OSC_A, rv); check("R4 osc", rv, DEF_WORD);
    check("R4 vco", {23'd0, vco_div}, 32'h030);
    check("R8 refused", {31'd0, cfg_update}, 32'd0);

    // R3 near-miss key keeps it closed
    wr(KEY_A, 32'h0001_A05F);
    rd(KEY_A, rv); check("R3 near key", rv, 32'h0001_A05F);

    // R2 open
    wr(KEY_A, 32'h0000_A05F);
    rd(KEY_A, rv); check("R2 key", rv, 32'h0000_A05F);
    check("R2 locked", {31'd0, locked}, 32'd0);

    // R5 R6 R7 R8 sweep of every VCO value, covering every reference value
    for (int v = 0; v < 512; v++) begin
      logic [31:0] w;
      w = {13'((v * 37) & 32'h1FFF), 3'(v % 8), 7'((v * 5) % 128), 9'(v)};
      wr(OSC_A, w);
      cur = expect_word(w);
      check("R8 strobe", {31'd0, cfg_update}, 32'd1);
      check("R5 R7 vco", {23'd0, vco_div}, {23'd0, cur[8:0]});
      check("R5 R7 ref", {25'd0, ref_div}, {25'd0, cur[15:9]});
      check("R5 sel", {29'd0, out_sel}, {29'd0, cur[18:16]});
      rd(OSC_A, rv); check("R6 R7 readback", rv, cur);
      @(negedge clk);
      check("R8 single", {31'd0, cfg_update}, 32'd0);
    end

    // R9 other addresses
    for (int a = 0; a < 16; a++) begin
      if (a != 2 && a != 5) begin
        wr(4'(a), 32'h0000_0000);
        rd(4'(a), rv); check("R9 other read", rv, 32'd0);
        check("R9 guard kept", {31'd0, locked}, 32'd0);
        rd(OSC_A, rv); check("R9 osc kept", rv, cur);
      end
    end

    // R3 close with zero, then osc write refused
    wr(KEY_A, 32'h0000_0000);
    rd(KEY_A, rv); check("R3 zero", rv, 32'h0001_0000);
    wr(OSC_A, 32'h0000_0000);
    rd(OSC_A, rv); check("R4 after close", rv, cur);
    check("R8 closed", {31'd0, cfg_update}, 32'd0);

    // R3 arbitrary key records low half
    wr(KEY_A, 32'h1234_5678);
    rd(KEY_A, rv); check("R3 record", rv, 32'h0001_5678);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule